// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Half-Duty Output

This block divides an input clock by a fixed odd integer N (at least 3). In its default mode the divided output is high for exactly half of every output period. For an odd ratio that is not a whole number of input cycles, so the block creates the half-cycle offset with two registers. A register clocked on the rising edge sets the coarse high window. A register clocked on the falling edge follows it half an input cycle later. The output is the AND of the two.

A second mode is selected at elaboration time. It drives the output straight from a single rising-edge register, so the output changes only on rising edges. Its duty is then not 50%: the output is high for (N-1)/2 input cycles and low for (N+1)/2. Reset is active-low. It is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `odd_div`

## Requirements
- R1: An internal counter steps by one on each rising edge and wraps to 0 after N-1, so the output period is exactly N input cycles (2N half-cycles).
- R2: While the reset input is low, the output is low and the counter is 0; asserting reset clears the output at once, without waiting for a clock edge.
- R3: In half-duty mode (MODE = DUTY_HALF) every high phase of the output lasts exactly N input half-cycles.
- R4: In half-duty mode every low phase of the output lasts exactly N input half-cycles, and the output drops in the same cycle in which the rising-edge window register drops.
- R5: In registered mode (MODE = DUTY_REG) the output is high for N-1 half-cycles and low for N+1 half-cycles, and it rises on the rising edge that moves the counter to 1.
- R6: The output rises for the first time within N+3 input cycles after reset is released.
- R7: N and MODE are parameters fixed at elaboration; an even N or an N below 3 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| clk_div_o | output | 1 | Divided clock output |

## Verification
The bench builds five copies side by side: half-duty mode with N = 3, 5 and 7, and registered mode with N = 3 and 5. N = 3 is the tightest case: there the rising-edge window is only two cycles long and the registered high phase is a single cycle. The larger ratios show that the half-cycle offset scales with N and does not only work for divide-by-3. An asynchronous reset in the middle of a run, followed by a second release, exercises re-synchronization and the first-edge bound twice.

// File: rtl/odd_div_pkg.sv
`timescale 1ns/1ps
package odd_div_pkg;

  // Output shaping variant, chosen at elaboration.
  typedef enum logic {
    DUTY_HALF = 1'b0,  // rising + falling register, 50% duty
    DUTY_REG  = 1'b1   // single rising-edge register, unbalanced duty
  } duty_mode_e;

endpackage

// File: rtl/odd_div_rst_sync.sv
`timescale 1ns/1ps
module odd_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/odd_div_modcnt.sv
`timescale 1ns/1ps
module odd_div_modcnt #(
  parameter int N = 3,
  parameter int W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/odd_div_shape.sv
`timescale 1ns/1ps
module odd_div_shape
  import odd_div_pkg::*;
#(
  parameter int         N    = 3,
  parameter int         W    = $clog2(N),
  parameter duty_mode_e MODE = DUTY_HALF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  output logic         lead_o,
  output logic         div_o
);

  // Cycles the rising-edge window stays high in each mode.
  localparam int WIN_HALF = (N + 1) / 2;
  localparam int WIN_REG  = (N - 1) / 2;
  localparam int WIN      = (MODE == DUTY_HALF) ? WIN_HALF : WIN_REG;
  localparam logic [W-1:0] WIN_END = W'(WIN);

  logic lead_q;
  logic lead_d;

  always_comb begin
    lead_d = (cnt_i < WIN_END);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_q <= 1'b0;
    end else begin
      lead_q <= lead_d;
    end
  end

  assign lead_o = lead_q;

  if (MODE == DUTY_HALF) begin : g_half
    // Copy of the window taken half a cycle later; the overlap
    // trims half a cycle from the window, giving N/2 cycles high.
    logic lag_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lag_q <= 1'b0;
      end else begin
        lag_q <= lead_q;
      end
    end
    assign div_o = lead_q & lag_q;
  end else begin : g_reg
    assign div_o = lead_q;
  end

endmodule

// File: rtl/odd_div.sv
`timescale 1ns/1ps
module odd_div
  import odd_div_pkg::*;
#(
  parameter int         N    = 3,
  parameter duty_mode_e MODE = DUTY_HALF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_div_o
);

  localparam int W = $clog2(N);

  // R7: only odd ratios of at least 3 are legal
  if ((N < 3) || ((N % 2) == 0)) begin : g_bad_ratio
    $error("odd_div: N must be odd and at least 3");
  end

  logic         rst_sync_n;
  logic [W-1:0] cnt_w;
  logic         lead_w;

  odd_div_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  odd_div_modcnt #(
    .N (N),
    .W (W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cnt_o  (cnt_w)
  );

  odd_div_shape #(
    .N    (N),
    .W    (W),
    .MODE (MODE)
  ) u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cnt_i  (cnt_w),
    .lead_o (lead_w),
    .div_o  (clk_div_o)
  );

endmodule

// File: rtl/odd_div_chk.sv
`timescale 1ns/1ps
module odd_div_chk
  import odd_div_pkg::*;
#(
  parameter int         N    = 3,
  parameter duty_mode_e MODE = DUTY_HALF,
  parameter int         W    = $clog2(N)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         srst_n,
  input logic [W-1:0] cnt,
  input logic         lead,
  input logic         div_o
);

  localparam logic [W-1:0] LAST = W'(N - 1);
  localparam logic [W-1:0] ONE  = W'(1);

  // R1: wrap after the last count
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!srst_n)
    (cnt == LAST) |=> (cnt == '0));

  // R1: single step otherwise
  assert_step_R1: assert property (@(posedge clk_i) disable iff (!srst_n)
    (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  // R2: reset holds output low and counter cleared
  assert_reset_low_R2: assert property (@(posedge clk_i)
    !rst_ni |-> (!div_o && (cnt == '0)));

  if (MODE == DUTY_HALF) begin : g_half
    // R3: output is high one cycle after the window opens
    assert_high_follows_R3: assert property (@(posedge clk_i) disable iff (!srst_n)
      $rose(lead) |=> div_o);
    // R4: output is low as soon as the window closes
    assert_low_with_window_R4: assert property (@(posedge clk_i) disable iff (!srst_n)
      $fell(lead) |-> !div_o);
  end else begin : g_reg
    // R5: registered output rises with the step to count 1
    assert_rise_at_one_R5: assert property (@(posedge clk_i) disable iff (!srst_n)
      $rose(div_o) |-> (cnt == ONE));
  end

endmodule

bind odd_div odd_div_chk #(.N(N), .MODE(MODE)) u_odd_div_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .srst_n (rst_sync_n),
  .cnt    (cnt_w),
  .lead   (lead_w),
  .div_o  (clk_div_o)
);

// File: tb/odd_div_bench.sv
`timescale 1ns/1ps
// Behavioural watcher: samples one divided clock 1 ns after every
// input edge and checks run lengths in half-cycles.
module odd_div_probe #(
  parameter int N    = 3,
  parameter bit HALF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output int   n_chk,
  output int   n_err,
  output int   n_chg
);

  localparam int HI_H = HALF ? N : N - 1;
  localparam int LO_H = HALF ? N : N + 1;

  int run;
  int since;
  int hi_len;
  bit prev;

  initial begin
    n_chk = 0; n_err = 0; n_chg = 0;
    run = 0; since = 0; hi_len = 0; prev = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s N=%0d half=%0d: actual %0d expected %0d", tag, N, HALF, act, exp);
    end
  endtask

  always @(clk) begin
    #1;
    if (!rst_n) begin
      if (since != 0 || n_chg != 0) chk(sig == 1'b0, "R2 output low in reset", int'(sig), 0);
      since = 0; run = 0; prev = 1'b0; hi_len = 0; n_chg = 0;
    end else begin
      since++;
      if (sig != prev) begin
        if (n_chg == 0) begin
          chk(since <= 2 * (N + 3), "R6 first rise half-cycles", since, 2 * (N + 3));
        end else if (prev) begin
          chk(run == HI_H, HALF ? "R3 high half-cycles" : "R5 high half-cycles", run, HI_H);
          hi_len = run;
        end else begin
          chk(run == LO_H, HALF ? "R4 low half-cycles" : "R5 low half-cycles", run, LO_H);
          if (hi_len != 0) chk(hi_len + run == 2 * N, "R1 period half-cycles", hi_len + run, 2 * N);
        end
        n_chg++;
        run = 1;
        prev = sig;
      end else begin
        run++;
      end
    end
  end

endmodule

module odd_div_bench;
  import odd_div_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d3, d5, d7, r3, r5;

  always #2.5 clk = ~clk;

  odd_div #(.N(3), .MODE(DUTY_HALF)) u_odd_div    (.clk_i(clk), .rst_ni(rst_n), .clk_div_o(d3));
  odd_div #(.N(5), .MODE(DUTY_HALF)) u_odd_div_n5 (.clk_i(clk), .rst_ni(rst_n), .clk_div_o(d5));
  odd_div #(.N(7), .MODE(DUTY_HALF)) u_odd_div_n7 (.clk_i(clk), .rst_ni(rst_n), .clk_div_o(d7));
  odd_div #(.N(3), .MODE(DUTY_REG))  u_odd_div_r3 (.clk_i(clk), .rst_ni(rst_n), .clk_div_o(r3));
  odd_div #(.N(5), .MODE(DUTY_REG))  u_odd_div_r5 (.clk_i(clk), .rst_ni(rst_n), .clk_div_o(r5));

  int c0, e0, g0, c1, e1, g1, c2, e2, g2, c3, e3, g3, c4, e4, g4;

  odd_div_probe #(.N(3), .HALF(1'b1)) p0 (.clk(clk), .rst_n(rst_n), .sig(d3), .n_chk(c0), .n_err(e0), .n_chg(g0));
  odd_div_probe #(.N(5), .HALF(1'b1)) p1 (.clk(clk), .rst_n(rst_n), .sig(d5), .n_chk(c1), .n_err(e1), .n_chg(g1));
  odd_div_probe #(.N(7), .HALF(1'b1)) p2 (.clk(clk), .rst_n(rst_n), .sig(d7), .n_chk(c2), .n_err(e2), .n_chg(g2));
  odd_div_probe #(.N(3), .HALF(1'b0)) p3 (.clk(clk), .rst_n(rst_n), .sig(r3), .n_chk(c3), .n_err(e3), .n_chg(g3));
  odd_div_probe #(.N(5), .HALF(1'b0)) p4 (.clk(clk), .rst_n(rst_n), .sig(r5), .n_chk(c4), .n_err(e4), .n_chg(g4));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      checks += c0 + c1 + c2 + c3 + c4;
      errors += e0 + e1 + e2 + e3 + e4;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic all_low(input string tag);
    chk({d3, d5, d7, r3, r5} == 5'b0, tag, int'({d3, d5, d7, r3, r5}), 0);
  endtask

  task automatic activity(input string tag);
    chk(g0 >= 10, tag, g0, 10);
    chk(g1 >= 10, tag, g1, 10);
    chk(g2 >= 10, tag, g2, 10);
    chk(g3 >= 10, tag, g3, 10);
    chk(g4 >= 10, tag, g4, 10);
  endtask

  initial begin
    #1;
    all_low("R2 outputs low at start of reset");
    repeat (4) @(posedge clk);
    #1.5;
    all_low("R2 outputs low before release");
    @(negedge clk);
    #0.5 rst_n = 1'b1;
    repeat (200) @(posedge clk);
    activity("R1 output toggling in first run");
    // R2: asynchronous assertion in the middle of a phase
    #1.7 rst_n = 1'b0;
    #0.3;
    all_low("R2 asynchronous clear");
    repeat (3) @(posedge clk);
    #1.5;
    all_low("R2 held low during reset");
    @(negedge clk);
    #0.5 rst_n = 1'b1;
    repeat (150) @(posedge clk);
    activity("R1 output toggling after second release");
    report();
  end

  initial begin
    #100000;
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

endmodule